// File: doc/BRIEF.md
# Low-Side Gate Channel Fault Controller

This block holds the control and fault logic for a bank of low-side switch pre-drivers (six channels by default). A channel is switched on by its parallel request pin or by its bit in a shared control register, which is written through a simple word-write port. One write can switch every channel at the same instant. The gate-enable outputs then go to external gate drive stages. The drain-monitor comparators report to the block as digital flags.

After every gate edge, each channel waits out a blank time chosen from its own configuration word. It then judges only the flags that suit its state. A channel that is on watches for a short to the supply. A channel that is off turns on its test current sources and watches for a short to ground and for an open load. A flag latches only if it stays high for a whole prescaler period. A short to the supply shuts the gate off. One retry timer, shared by all channels, clears those shutdowns when it expires. Ground-short and open-load faults stay latched until a status read. The configuration word also selects each channel's comparator thresholds, and these leave the block as select codes.

Top module: `lsd_fault_ctrl`

## Requirements
- R1: Each channel has its own 8-bit configuration word, written when `wr_en` is high and `wr_addr` equals the channel number (0 to NCH-1). Its fields are: bits [1:0] on-blank select, [3:2] off-blank select, [6:4] supply-short threshold code, [7] ground-short threshold code. A write to one channel leaves the other channels unchanged.
- R2: A channel's gate output is high only while reset is low, no supply-short fault is latched on that channel, and either `in_req[i]` or control bit i is high. The control register is written at address NCH from `wr_data[NCH-1:0]`, so one write switches all channels in the same cycle.
- R3: While a channel's gate is on, only the supply-short flag is evaluated. While it is off, `src_en[i]` is high and only the ground-short and open-load flags are evaluated.
- R4: After each gate edge, flags are ignored for BLANK_BASE shifted left by the selected 2-bit code prescaler ticks. The on-blank field applies after a rising edge and the off-blank field after a falling edge.
- R5: After the blank time, a flag latches only if it stays high for every cycle of a full prescaler period. A flag that toggles every cycle never latches.
- R6: `stb_thr_sel[3i+2:3i]` and `stg_thr_sel[i]` always show the threshold fields of channel i's configuration word.
- R7: A latched supply-short fault turns the gate off. One shared retry counter runs only while at least one supply-short fault is latched. After RETRY_CYCLES cycles it clears every supply-short fault, and the gate turns back on if it is still requested.
- R8: A latched ground-short or open-load fault stays set until `stat_rd` is high. If a new fault latches in the same cycle as a read, the new fault is kept.
- R9: Reset turns all gates off, restores every configuration word and the control register to their defaults, clears all faults and sets `reset_seen`. A status read clears `reset_seen`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_req | input | NCH | Parallel on-requests, one per channel |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Channel number, or NCH for the control register |
| wr_data | input | DW | Write data |
| stat_rd | input | 1 | Status read: clears ground-short and open-load faults and `reset_seen` |
| stb_flag | input | NCH | Supply-short comparator flags |
| stg_flag | input | NCH | Ground-short comparator flags |
| ol_flag | input | NCH | Open-load comparator flags |
| gate_en | output | NCH | Gate enable per channel |
| src_en | output | NCH | Test current source enable (high while the gate is off) |
| stb_fault | output | NCH | Latched supply-short faults |
| stg_fault | output | NCH | Latched ground-short faults |
| ol_fault | output | NCH | Latched open-load faults |
| stb_thr_sel | output | 3*NCH | Supply-short threshold codes |
| stg_thr_sel | output | NCH | Ground-short threshold codes |
| reset_seen | output | 1 | Latched-reset status |

## Verification
A status read can clear a ground-short latch in the same cycle that a qualified ground-short flag sets it. The bench provokes this by holding `stat_rd` high for many prescaler periods while a channel that is off sees a steady ground-short flag, so the clear falls on every latch cycle. It counts the cycles in which the fault output is high. The count must be nonzero, because if the clear took priority the fault would never appear. Once both the flag and the read have ended, the fault must read zero.

// File: rtl/lsd_pkg.sv
package lsd_pkg;
  // Per-channel configuration word, MSB first
  typedef struct packed {
    logic       stg_thr;
    logic [2:0] stb_thr;
    logic [1:0] off_blank;
    logic [1:0] on_blank;
  } ch_cfg_t;

  localparam int CFG_W = $bits(ch_cfg_t);
endpackage

// File: rtl/lsd_prescaler.sv
module lsd_prescaler #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int W = (DIV > 2) ? $clog2(DIV) : 1;
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == W'(DIV - 1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/lsd_retry.sv
module lsd_retry #(
  parameter int PERIOD = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic any_stb,
  output logic fire
);
  localparam int W = $clog2(PERIOD + 1);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !any_stb) begin
      cnt  <= '0;
      fire <= 1'b0;
    end else if (cnt == W'(PERIOD - 1)) begin
      cnt  <= '0;
      fire <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      fire <= 1'b0;
    end
  end

  // R7: the shared timer only fires while a supply-short shutdown is held
  a_r7_fire_needs_fault: assert property (@(posedge clk) disable iff (rst)
    fire |-> any_stb);
endmodule

// File: rtl/lsd_channel.sv
module lsd_channel
  import lsd_pkg::*;
#(
  parameter int BLANK_BASE = 2
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    tick,
  input  logic    req,
  input  ch_cfg_t cfg,
  input  logic    stb_flag,
  input  logic    stg_flag,
  input  logic    ol_flag,
  input  logic    retry,
  input  logic    clr_rd,
  output logic    gate,
  output logic    src_en,
  output logic    stb_f,
  output logic    stg_f,
  output logic    ol_f
);
  localparam int BW = $clog2((BLANK_BASE << 3) + 1);

  logic [BW-1:0] blank;
  logic [2:0]    held;      // {stb, stg, ol} high since window start
  logic          gate_nxt, steady, window_end;
  logic          set_stb, set_stg, set_ol;

  function automatic logic [BW-1:0] blank_len(input logic [1:0] sel);
    return BW'(BLANK_BASE << sel);
  endfunction

  assign gate_nxt   = req & ~stb_f;
  assign steady     = (gate_nxt == gate);
  assign window_end = steady && tick && (blank == '0);
  assign set_stb    = window_end &&  gate && held[2] && stb_flag;
  assign set_stg    = window_end && !gate && held[1] && stg_flag;
  assign set_ol     = window_end && !gate && held[0] && ol_flag;
  assign src_en     = ~gate;

  always_ff @(posedge clk) begin
    if (rst) begin
      gate  <= 1'b0;
      blank <= '0;
      held  <= '0;
    end else begin
      gate <= gate_nxt;
      if (!steady) begin
        blank <= blank_len(gate_nxt ? cfg.on_blank : cfg.off_blank);
        held  <= '0;
      end else if (tick) begin
        held <= 3'b111;
        if (blank != '0) blank <= blank - 1'b1;
      end else begin
        held <= held & {stb_flag, stg_flag, ol_flag};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stb_f <= 1'b0;
      stg_f <= 1'b0;
      ol_f  <= 1'b0;
    end else begin
      if (set_stb)     stb_f <= 1'b1;
      else if (retry)  stb_f <= 1'b0;
      if (set_stg)     stg_f <= 1'b1;
      else if (clr_rd) stg_f <= 1'b0;
      if (set_ol)      ol_f  <= 1'b1;
      else if (clr_rd) ol_f  <= 1'b0;
    end
  end

  // R2/R7: a latched supply short takes the gate down on the next edge
  a_r7_stb_kills_gate: assert property (@(posedge clk) disable iff (rst)
    stb_f |=> !gate);
  // R3: supply short is judged only while on, ground short only while off
  a_r3_stb_only_on: assert property (@(posedge clk) disable iff (rst)
    $rose(stb_f) |-> $past(gate));
  a_r3_stg_only_off: assert property (@(posedge clk) disable iff (rst)
    $rose(stg_f) |-> !$past(gate));
  // R4: no fault may latch while a blank count is still running
  a_r4_blank_done: assert property (@(posedge clk) disable iff (rst)
    ($rose(stb_f) || $rose(stg_f) || $rose(ol_f)) |-> $past(blank == '0));
  // R5: a latch needs the flag present in its final cycle
  a_r5_ol_flag_present: assert property (@(posedge clk) disable iff (rst)
    $rose(ol_f) |-> $past(ol_flag));
endmodule

// File: rtl/lsd_fault_ctrl.sv
module lsd_fault_ctrl
  import lsd_pkg::*;
#(
  parameter int          NCH          = 6,
  parameter int          PRESC        = 8,
  parameter int          BLANK_BASE   = 2,
  parameter int          RETRY_CYCLES = 4096,
  parameter logic [7:0]  CFG_RST      = 8'h00,
  localparam int         AW           = $clog2(NCH + 1),
  localparam int         DW           = (NCH > CFG_W) ? NCH : CFG_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCH-1:0]   in_req,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic             stat_rd,
  input  logic [NCH-1:0]   stb_flag,
  input  logic [NCH-1:0]   stg_flag,
  input  logic [NCH-1:0]   ol_flag,
  output logic [NCH-1:0]   gate_en,
  output logic [NCH-1:0]   src_en,
  output logic [NCH-1:0]   stb_fault,
  output logic [NCH-1:0]   stg_fault,
  output logic [NCH-1:0]   ol_fault,
  output logic [3*NCH-1:0] stb_thr_sel,
  output logic [NCH-1:0]   stg_thr_sel,
  output logic             reset_seen
);
  ch_cfg_t        cfg_q [NCH];
  logic [NCH-1:0] ctrl_q;
  logic           tick, retry_fire;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NCH; k++) cfg_q[k] <= ch_cfg_t'(CFG_RST);
      ctrl_q <= '0;
    end else if (wr_en) begin
      if (wr_addr == AW'(NCH))     ctrl_q <= wr_data[NCH-1:0];
      else if (wr_addr < AW'(NCH)) cfg_q[wr_addr] <= ch_cfg_t'(wr_data[CFG_W-1:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          reset_seen <= 1'b1;
    else if (stat_rd) reset_seen <= 1'b0;
  end

  lsd_prescaler #(.DIV(PRESC)) u_presc (
    .clk(clk), .rst(rst), .tick(tick)
  );

  lsd_retry #(.PERIOD(RETRY_CYCLES)) u_retry (
    .clk(clk), .rst(rst), .any_stb(|stb_fault), .fire(retry_fire)
  );

  for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
    lsd_channel #(.BLANK_BASE(BLANK_BASE)) u_ch (
      .clk     (clk),
      .rst     (rst),
      .tick    (tick),
      .req     (in_req[gi] | ctrl_q[gi]),
      .cfg     (cfg_q[gi]),
      .stb_flag(stb_flag[gi]),
      .stg_flag(stg_flag[gi]),
      .ol_flag (ol_flag[gi]),
      .retry   (retry_fire),
      .clr_rd  (stat_rd),
      .gate    (gate_en[gi]),
      .src_en  (src_en[gi]),
      .stb_f   (stb_fault[gi]),
      .stg_f   (stg_fault[gi]),
      .ol_f    (ol_fault[gi])
    );
    assign stb_thr_sel[3*gi +: 3] = cfg_q[gi].stb_thr;
    assign stg_thr_sel[gi]        = cfg_q[gi].stg_thr;

    // R2: a gate is only on when something asked for it a cycle earlier
    a_r2_gate_needs_req: assert property (@(posedge clk) disable iff (rst)
      gate_en[gi] |-> $past(in_req[gi] | ctrl_q[gi]));
  end

  // R9: reset leaves every gate off, all faults clear and the flag set
  a_r9_reset_state: assert property (@(posedge clk)
    rst |=> (gate_en == '0 && stb_fault == '0 && stg_fault == '0 &&
             ol_fault == '0 && reset_seen));
endmodule

// File: tb/lsd_fault_ctrl_bench.sv
module lsd_fault_ctrl_bench;
  localparam int NCH = 6;
  localparam int AW  = $clog2(NCH + 1);
  localparam int DW  = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [NCH-1:0]   in_req = '0;
  logic             wr_en = 1'b0;
  logic [AW-1:0]    wr_addr = '0;
  logic [DW-1:0]    wr_data = '0;
  logic             stat_rd = 1'b0;
  logic [NCH-1:0]   stb_flag = '0, stg_flag = '0, ol_flag = '0;
  logic [NCH-1:0]   gate_en, src_en, stb_fault, stg_fault, ol_fault, stg_thr_sel;
  logic [3*NCH-1:0] stb_thr_sel;
  logic             reset_seen;

  int checks = 0, failures = 0;
  int obs = 0;
  bit done = 0;

  always #4 clk = ~clk;

  lsd_fault_ctrl #(.NCH(NCH), .PRESC(4), .BLANK_BASE(2), .RETRY_CYCLES(200))
  u_lsd_fault_ctrl (
    .clk(clk), .rst(rst), .in_req(in_req), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .stat_rd(stat_rd), .stb_flag(stb_flag),
    .stg_flag(stg_flag), .ol_flag(ol_flag), .gate_en(gate_en), .src_en(src_en),
    .stb_fault(stb_fault), .stg_fault(stg_fault), .ol_fault(ol_fault),
    .stb_thr_sel(stb_thr_sel), .stg_thr_sel(stg_thr_sel), .reset_seen(reset_seen)
  );

  typedef struct { string tag; int sel; int ch; int exp; } item_t;
  item_t sb [$];

  function automatic int observe(input int sel, input int ch);
    case (sel)
      0: return int'(gate_en[ch]);
      1: return int'(stb_fault[ch]);
      2: return int'(stg_fault[ch]);
      3: return int'(ol_fault[ch]);
      4: return int'(src_en[ch]);
      5: return int'(stb_thr_sel[3*ch +: 3]);
      6: return int'(stg_thr_sel[ch]);
      7: return int'(reset_seen);
      8: return int'(gate_en);
      default: return obs;
    endcase
  endfunction

  // monitor: pops expected items and compares against the design
  always @(negedge clk) begin
    while (sb.size() != 0) begin
      item_t it;
      int act;
      it  = sb.pop_front();
      act = observe(it.sel, it.ch);
      checks++;
      if (act != it.exp) begin
        failures++;
        $display("FAIL %s sel=%0d ch=%0d actual=%0d expected=%0d",
                 it.tag, it.sel, it.ch, act, it.exp);
      end
    end
  end

  task automatic expect_v(input string tag, input int sel, input int ch, input int exp);
    item_t it;
    it.tag = tag; it.sel = sel; it.ch = ch; it.exp = exp;
    sb.push_back(it);
    while (sb.size() != 0) @(negedge clk);
    @(posedge clk); #1;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input int addr, input int data);
    wr_en = 1'b1; wr_addr = AW'(addr); wr_data = DW'(data);
    cyc(1);
    wr_en = 1'b0;
  endtask

  task automatic status_read();
    stat_rd = 1'b1; cyc(1); stat_rd = 1'b0; cyc(1);
  endtask

  initial begin
    cyc(5);
    rst = 1'b0;
    cyc(1);
    // R9 reset state
    expect_v("R9 gates off", 8, 0, 0);
    expect_v("R9 reset_seen set", 7, 0, 1);
    expect_v("R3 sources on while off", 4, 2, 1);
    status_read();
    expect_v("R9 read clears reset_seen", 7, 0, 0);

    // R1 / R6 config word fields
    wr(2, 8'b1_101_00_00);
    cyc(1);
    expect_v("R6 stb threshold ch2", 5, 2, 5);
    expect_v("R6 stg threshold ch2", 6, 2, 1);
    expect_v("R1 ch3 untouched", 5, 3, 0);

    // R2 parallel request
    in_req[0] = 1'b1; cyc(2);
    expect_v("R2 parallel on", 0, 0, 1);
    expect_v("R3 sources off while on", 4, 0, 0);

    // R3 ground flag ignored while on
    stg_flag[0] = 1'b1; cyc(100);
    expect_v("R3 stg ignored while on", 2, 0, 0);
    expect_v("R3 gate stays on", 0, 0, 1);
    stg_flag[0] = 1'b0; in_req[0] = 1'b0; cyc(2);

    // R2 one control write switches all channels together
    wr(NCH, 6'h3F); cyc(1);
    expect_v("R2 all on in one write", 8, 0, 63);
    wr(NCH, 0); cyc(1);
    expect_v("R2 all off in one write", 8, 0, 0);
    cyc(40);

    // R3 supply flag ignored while off
    stb_flag[1] = 1'b1; cyc(60);
    expect_v("R3 stb ignored while off", 1, 1, 0);
    stb_flag[1] = 1'b0; cyc(2);

    // R4 short on-blank, R7 shutdown and retry
    wr(4, 8'b0_000_00_00);
    stb_flag[4] = 1'b1; in_req[4] = 1'b1; cyc(24);
    expect_v("R4 short blank latches stb", 1, 4, 1);
    expect_v("R7 stb turns gate off", 0, 4, 0);
    stb_flag[4] = 1'b0; cyc(36);
    expect_v("R7 still off before retry", 0, 4, 0);
    cyc(200);
    expect_v("R7 retry clears stb", 1, 4, 0);
    expect_v("R7 gate back on after retry", 0, 4, 1);
    in_req[4] = 1'b0; cyc(2);

    // R4 long on-blank masks the flag
    wr(5, 8'b0_000_00_11);
    stb_flag[5] = 1'b1; in_req[5] = 1'b1; cyc(40);
    expect_v("R4 long blank masks stb", 1, 5, 0);
    expect_v("R4 gate on during blank", 0, 5, 1);
    cyc(60);
    expect_v("R4 stb latched after long blank", 1, 5, 1);
    stb_flag[5] = 1'b0; in_req[5] = 1'b0; cyc(260);
    expect_v("R7 cleared for ch5", 1, 5, 0);

    // R8 open load sticky until read
    ol_flag[3] = 1'b1; cyc(20);
    expect_v("R8 ol latched", 3, 3, 1);
    ol_flag[3] = 1'b0; cyc(20);
    expect_v("R8 ol sticky", 3, 3, 1);
    status_read();
    expect_v("R8 ol cleared by read", 3, 3, 0);

    // R5 a flag toggling every cycle never qualifies
    for (int i = 0; i < 40; i++) begin
      stg_flag[3] = i[0]; cyc(1);
    end
    stg_flag[3] = 1'b0; cyc(1);
    expect_v("R5 toggling flag rejected", 2, 3, 0);

    // R8 set wins over a read in the same cycle
    obs = 0;
    stat_rd = 1'b1; stg_flag[3] = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (stg_fault[3]) obs++;
      @(posedge clk); #1;
    end
    stg_flag[3] = 1'b0;
    obs = (obs > 0) ? 1 : 0;
    expect_v("R8 latch survives concurrent read", 9, 0, 1);
    cyc(2); stat_rd = 1'b0; cyc(1);
    expect_v("R8 cleared after read ends", 2, 3, 0);

    // R9 reset restores defaults and turns gates off
    in_req[0] = 1'b1; ol_flag[1] = 1'b1; cyc(20);
    rst = 1'b1; cyc(2);
    expect_v("R9 gate off during reset", 0, 0, 0);
    expect_v("R9 fault cleared", 3, 1, 0);
    ol_flag[1] = 1'b0; in_req[0] = 1'b0;
    rst = 1'b0; cyc(1);
    expect_v("R9 cfg restored", 5, 2, 0);
    expect_v("R9 reset_seen set again", 7, 0, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule